// File: doc/BRIEF.md
# Interrupt Status and Mask Register Block

This block collects single-cycle event pulses from a bus controller into a sticky status register and raises one interrupt line when any pending event is not masked. Software clears pending events by writing ones to the status register. It changes the mask only through two write-only ports: a write-one-to-unmask port and a write-one-to-mask port. The mask itself can be read back but not written directly. A second line flags pending unmasked events that belong to the error group.

Register access uses a plain strobe interface. A write takes effect at the clock edge where `wr_en` is sampled. A read is sampled on `rd_en`, and its data is returned one cycle later with `rd_valid`. A small access state machine sequences read responses. Its two states are `ACC_IDLE` (no response pending) and `ACC_RDATA` (read data is valid on `rdata`). The transitions are: `ACC_IDLE` to `ACC_RDATA` when `rd_en` is high, `ACC_RDATA` stays in `ACC_RDATA` when `rd_en` is high again, and `ACC_RDATA` returns to `ACC_IDLE` when `rd_en` is low. All registers share one bit layout:

| Bit | Event |
|-----|-------|
| 0 | completion |
| 1 | data |
| 2 | NACK |
| 3 | timeout |
| 4 | slave ready |
| 5 | RX overflow |
| 6 | TX overflow |
| 7 | RX underflow |
| 9 | arbitration lost |

Bit 8 is not implemented.

Top module: `irq_ctrl_regs`

## Requirements
- R1: After reset, status reads 0x000, the mask reads 0x2FF (every implemented source masked), and `irq`, `err_irq` and `rd_valid` are low.
- R2: A one on `ev_pulse[i]` for an implemented bit i (0 to 7 or 9) sets status bit i at that clock edge. The bit then stays set until it is cleared.
- R3: A write to offset 0x10 clears exactly the status bits written as one. Zero bits have no effect, so writing back a value read from status clears exactly the bits that were set.
- R4: If an event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R5: Writing one to a bit at offset 0x24 unmasks that source, so the mask bit reads 0. Zero bits leave the mask unchanged.
- R6: Writing one to a bit at offset 0x28 masks that source, so the mask bit reads 1. Zero bits leave the mask unchanged.
- R7: The mask reads at offset 0x20, and writes to 0x20 have no effect.
- R8: `irq` is a register. In the cycle after any edge, it equals the OR over all bits of status AND NOT mask as they stood after that edge.
- R9: `err_irq` is a register. It follows the same rule as R8, but only over the error group: bits 2, 5, 6, 7 and 9.
- R10: Bit 8 and bits above 9 read as zero in status and mask. An event on bit 8 is ignored. Reads of 0x24, 0x28 and unmapped offsets return zero.
- R11: A read sampled on `rd_en` returns its data on `rdata` with `rd_valid` high in the next cycle. The data is the register value from before any write in the same cycle, and back-to-back reads give back-to-back responses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_pulse | input | 10 | Event pulses from the controller, one per status bit |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 10 | Write data, in the shared bit layout |
| rdata | output | 32 | Read data, zero-extended |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| irq | output | 1 | Any unmasked pending event |
| err_irq | output | 1 | Any unmasked pending error-group event |

## Verification
Status and mask change at the edge where the event or write is sampled. Read data and `rd_valid` appear one cycle after the read strobe. `irq` and `err_irq` trail the register change by one more edge, so they respond two edges after the event or write that caused the change. The bench drives every stimulus on a falling edge and updates its own model at the next rising edge. It checks both interrupt lines on the falling edge after that, against values the model computed one edge earlier. Expected read values are queued when the read is issued and popped by a monitor on the falling edge where `rd_valid` is due.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
    localparam int SRC_W_DEF  = 10;
    localparam int ADDR_W_DEF = 8;
    localparam int DATA_W_DEF = 32;

    // implemented sources: bits 0..7 and 9
    localparam logic [SRC_W_DEF-1:0] IMPL_DEF = 10'h2FF;
    // error group: NACK, RX overflow, TX overflow, RX underflow, arbitration lost
    localparam logic [SRC_W_DEF-1:0] ERR_DEF  = 10'h2E4;

    localparam logic [ADDR_W_DEF-1:0] OFS_STATUS_DEF = 8'h10;
    localparam logic [ADDR_W_DEF-1:0] OFS_MASK_DEF   = 8'h20;
    localparam logic [ADDR_W_DEF-1:0] OFS_UNMASK_DEF = 8'h24;
    localparam logic [ADDR_W_DEF-1:0] OFS_MASKON_DEF = 8'h28;

    typedef enum logic {
        ACC_IDLE  = 1'b0,
        ACC_RDATA = 1'b1
    } acc_state_e;
endpackage

// File: rtl/irq_bus_fsm.sv
module irq_bus_fsm
    import irq_regs_pkg::*;
#(
    parameter int SRC_W  = SRC_W_DEF,
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF,
    parameter logic [ADDR_W-1:0] OFS_STATUS = OFS_STATUS_DEF,
    parameter logic [ADDR_W-1:0] OFS_MASK   = OFS_MASK_DEF,
    parameter logic [ADDR_W-1:0] OFS_UNMASK = OFS_UNMASK_DEF,
    parameter logic [ADDR_W-1:0] OFS_MASKON = OFS_MASKON_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SRC_W-1:0]  wdata,
    input  logic [SRC_W-1:0]  status,
    input  logic [SRC_W-1:0]  mask,
    output logic [SRC_W-1:0]  clr_bits,
    output logic [SRC_W-1:0]  unmask_bits,
    output logic [SRC_W-1:0]  maskon_bits,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_valid
);
    acc_state_e state_q, state_d;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] rdata_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACC_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE:  if (rd_en)  state_d = ACC_RDATA;
            ACC_RDATA: if (!rd_en) state_d = ACC_IDLE;
            default:   state_d = ACC_IDLE;
        endcase
    end

    // read selection, zero-extended
    always_comb begin
        rd_word = '0;
        if (addr == OFS_STATUS)    rd_word[SRC_W-1:0] = status;
        else if (addr == OFS_MASK) rd_word[SRC_W-1:0] = mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_word;
    end

    // outputs
    always_comb begin
        rd_valid    = (state_q == ACC_RDATA);
        rdata       = rdata_q;
        clr_bits    = (wr_en && addr == OFS_STATUS) ? wdata : '0;
        unmask_bits = (wr_en && addr == OFS_UNMASK) ? wdata : '0;
        maskon_bits = (wr_en && addr == OFS_MASKON) ? wdata : '0;
    end

    assert_rd_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    assert_rd_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
    import irq_regs_pkg::*;
#(
    parameter int SRC_W = SRC_W_DEF,
    parameter logic [SRC_W-1:0] IMPL = IMPL_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] ev,
    input  logic [SRC_W-1:0] clr,
    output logic [SRC_W-1:0] status
);
    for (genvar i = 0; i < SRC_W; i++) begin : g_bit
        if (IMPL[i]) begin : g_flop
            logic bit_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      bit_q <= 1'b0;
                else if (ev[i])  bit_q <= 1'b1;   // event wins over clear
                else if (clr[i]) bit_q <= 1'b0;
            end
            assign status[i] = bit_q;
        end else begin : g_none
            assign status[i] = 1'b0;
        end
    end

    assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev & IMPL) != '0) |=> ((status & $past(ev & IMPL)) == $past(ev & IMPL)));
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev & IMPL) == '0) |=> ((status & ~$past(status)) == '0));
    assert_clear_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr & ~ev) != '0) |=> ((status & $past(clr & ~ev)) == '0));
    assert_event_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev & clr & IMPL) != '0) |=> ((status & $past(ev & clr & IMPL)) == $past(ev & clr & IMPL)));
    assert_unimpl_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (status & ~IMPL) == '0);
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
    import irq_regs_pkg::*;
#(
    parameter int SRC_W = SRC_W_DEF,
    parameter logic [SRC_W-1:0] IMPL = IMPL_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] unmask_bits,
    input  logic [SRC_W-1:0] maskon_bits,
    output logic [SRC_W-1:0] mask
);
    for (genvar i = 0; i < SRC_W; i++) begin : g_bit
        if (IMPL[i]) begin : g_flop
            logic bit_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)              bit_q <= 1'b1;
                else if (maskon_bits[i]) bit_q <= 1'b1;
                else if (unmask_bits[i]) bit_q <= 1'b0;
            end
            assign mask[i] = bit_q;
        end else begin : g_none
            assign mask[i] = 1'b0;
        end
    end

    assert_unmask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((unmask_bits != '0) && (maskon_bits == '0)) |=> ((mask & $past(unmask_bits)) == '0));
    assert_maskon_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (maskon_bits != '0) |=> ((mask & $past(maskon_bits)) == $past(maskon_bits & IMPL)));
    assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((unmask_bits == '0) && (maskon_bits == '0)) |=> $stable(mask));
endmodule

// File: rtl/irq_line_gen.sv
module irq_line_gen
    import irq_regs_pkg::*;
#(
    parameter int SRC_W = SRC_W_DEF,
    parameter logic [SRC_W-1:0] ERR = ERR_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] status,
    input  logic [SRC_W-1:0] mask,
    output logic             irq,
    output logic             err_irq
);
    logic [SRC_W-1:0] live;
    logic irq_q, err_q;

    assign live = status & ~mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            irq_q <= |live;
            err_q <= |(live & ERR);
        end
    end

    assign irq     = irq_q;
    assign err_irq = err_q;

    assert_irq_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(status & ~mask))));
    assert_err_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (err_irq == $past(|(status & ~mask & ERR))));
    assert_err_implies_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> irq);
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
    import irq_regs_pkg::*;
#(
    parameter int SRC_W  = SRC_W_DEF,
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF,
    parameter logic [SRC_W-1:0]  IMPL = IMPL_DEF,
    parameter logic [SRC_W-1:0]  ERR  = ERR_DEF,
    parameter logic [ADDR_W-1:0] OFS_STATUS = OFS_STATUS_DEF,
    parameter logic [ADDR_W-1:0] OFS_MASK   = OFS_MASK_DEF,
    parameter logic [ADDR_W-1:0] OFS_UNMASK = OFS_UNMASK_DEF,
    parameter logic [ADDR_W-1:0] OFS_MASKON = OFS_MASKON_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_W-1:0]  ev_pulse,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SRC_W-1:0]  wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_valid,
    output logic              irq,
    output logic              err_irq
);
    logic [SRC_W-1:0] status, mask;
    logic [SRC_W-1:0] clr_bits, unmask_bits, maskon_bits;

    irq_bus_fsm #(
        .SRC_W(SRC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .OFS_STATUS(OFS_STATUS), .OFS_MASK(OFS_MASK),
        .OFS_UNMASK(OFS_UNMASK), .OFS_MASKON(OFS_MASKON)
    ) u_bus (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .status(status), .mask(mask),
        .clr_bits(clr_bits), .unmask_bits(unmask_bits), .maskon_bits(maskon_bits),
        .rdata(rdata), .rd_valid(rd_valid)
    );

    irq_status_reg #(.SRC_W(SRC_W), .IMPL(IMPL)) u_status (
        .clk(clk), .rst_n(rst_n), .ev(ev_pulse), .clr(clr_bits), .status(status)
    );

    irq_mask_reg #(.SRC_W(SRC_W), .IMPL(IMPL)) u_mask (
        .clk(clk), .rst_n(rst_n), .unmask_bits(unmask_bits),
        .maskon_bits(maskon_bits), .mask(mask)
    );

    irq_line_gen #(.SRC_W(SRC_W), .ERR(ERR)) u_line (
        .clk(clk), .rst_n(rst_n), .status(status), .mask(mask),
        .irq(irq), .err_irq(err_irq)
    );
endmodule

// File: tb/tb_irq_ctrl_regs.sv
`timescale 1ns/1ps
module tb_irq_ctrl_regs;
    localparam logic [9:0] IMPL = 10'h2FF;
    localparam logic [9:0] ERRG = 10'h2E4;
    localparam logic [7:0] A_ST = 8'h10, A_MK = 8'h20, A_UN = 8'h24, A_MO = 8'h28;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [9:0] ev_pulse = '0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] addr = '0;
    logic [9:0] wdata = '0;
    logic [31:0] rdata;
    logic rd_valid, irq, err_irq;

    int checks = 0;
    int errors = 0;

    logic [9:0] m_status = '0;
    logic [9:0] m_mask = IMPL;
    logic [31:0] q_exp[$];
    string q_tag[$];

    always #2 clk = ~clk;

    irq_ctrl_regs dut (
        .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
        .irq(irq), .err_irq(err_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] a);
        if (a == A_ST) return {22'd0, m_status};
        if (a == A_MK) return {22'd0, m_mask};
        return 32'd0;
    endfunction

    // monitor: pop expected read responses
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (q_exp.size() == 0) check("R11 unexpected rd_valid", 32'd1, 32'd0);
            else check(q_tag.pop_front(), rdata, q_exp.pop_front());
        end
    end

    // driver: one cycle of stimulus, called on a falling edge
    task automatic op(input logic [9:0] ev, input logic wr, input logic rd,
                      input logic [7:0] a, input logic [9:0] wd, input string tag);
        logic nirq, nerr;
        logic [9:0] ns, nm;
        ev_pulse = ev; wr_en = wr; rd_en = rd; addr = a; wdata = wd;
        if (rd) begin
            q_exp.push_back(model_read(a));
            q_tag.push_back(tag);
        end
        nirq = |(m_status & ~m_mask);
        nerr = |(m_status & ~m_mask & ERRG);
        ns = m_status;
        nm = m_mask;
        if (wr && a == A_ST) ns = ns & ~wd;
        ns = (ns | ev) & IMPL;
        if (wr && a == A_UN) nm = nm & ~wd;
        if (wr && a == A_MO) nm = (nm | wd) & IMPL;
        @(posedge clk);
        m_status = ns;
        m_mask = nm;
        @(negedge clk);
        check("R8 irq", {31'd0, irq}, {31'd0, nirq});
        check("R9 err_irq", {31'd0, err_irq}, {31'd0, nerr});
        ev_pulse = '0; wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) op('0, 1'b0, 1'b0, 8'h00, '0, "idle");
    endtask

    initial begin
        #(4 * 100000);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq reset", {31'd0, irq}, 32'd0);
        check("R1 err reset", {31'd0, err_irq}, 32'd0);
        check("R1 rd_valid reset", {31'd0, rd_valid}, 32'd0);
        op('0, 0, 1, A_ST, '0, "R1 status reset");
        op('0, 0, 1, A_MK, '0, "R1 mask reset");

        // R2 event sets status, masked so no irq
        op(10'h001, 0, 0, 8'h00, '0, "R2 event");
        idle(1);
        op('0, 0, 1, A_ST, '0, "R2 status sticky");
        check("R2 masked irq low", {31'd0, irq}, 32'd0);

        // R5 unmask bit 0 -> irq
        op('0, 1, 0, A_UN, 10'h001, "R5 unmask");
        idle(1);
        check("R5 irq raised", {31'd0, irq}, 32'd1);
        op('0, 0, 1, A_MK, '0, "R5 mask read");
        op('0, 1, 0, A_UN, 10'h000, "R5 zero write");
        op('0, 0, 1, A_MK, '0, "R5 zero bits no effect");

        // R10 bit 8 ignored; events on 9 and 2
        op(10'h304, 0, 0, 8'h00, '0, "R2 multi event");
        op('0, 0, 1, A_ST, '0, "R10 bit8 ignored");
        op('0, 1, 0, A_UN, 10'h204, "R9 unmask errors");
        idle(1);
        check("R9 err raised", {31'd0, err_irq}, 32'd1);

        // R3 clear semantics
        op('0, 1, 0, A_ST, 10'h000, "R3 zero clear");
        op('0, 0, 1, A_ST, '0, "R3 zero write no effect");
        op('0, 1, 0, A_ST, 10'h004, "R3 clear bit2");
        op('0, 0, 1, A_ST, '0, "R3 only bit2 cleared");

        // R4 event wins over clear
        op(10'h200, 1, 0, A_ST, 10'h200, "R4 collide");
        op('0, 0, 1, A_ST, '0, "R4 event wins");

        // R3 write back the read value
        op('0, 1, 0, A_ST, 10'h201, "R3 write back");
        op('0, 0, 1, A_ST, '0, "R3 all cleared");
        idle(1);
        check("R8 irq dropped", {31'd0, irq}, 32'd0);

        // R7 direct mask write ignored
        op('0, 1, 0, A_MK, 10'h000, "R7 direct write");
        op('0, 0, 1, A_MK, '0, "R7 mask unchanged");

        // R6 mask bit 0 again; event there gives no irq
        op('0, 1, 0, A_MO, 10'h001, "R6 maskon");
        op(10'h001, 0, 0, 8'h00, '0, "R6 event masked");
        idle(1);
        check("R6 irq stays low", {31'd0, irq}, 32'd0);
        op('0, 0, 1, A_MK, '0, "R6 mask read");

        // R10 write-only and unmapped reads
        op('0, 0, 1, A_UN, '0, "R10 read unmask port");
        op('0, 0, 1, A_MO, '0, "R10 read maskon port");
        op('0, 0, 1, 8'h14, '0, "R10 read unmapped");

        // R11 read with write in same cycle returns old value; back-to-back
        op(10'h080, 0, 0, 8'h00, '0, "R11 setup");
        op('0, 1, 1, A_ST, 10'h080, "R11 read during clear");
        op('0, 0, 1, A_ST, '0, "R11 back-to-back 1");
        op('0, 0, 1, A_MK, '0, "R11 back-to-back 2");
        idle(2);
        check("R11 queue drained", q_exp.size(), 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule